// File: doc/BRIEF.md
# Burst Capture Sequencer

This block paces burst acquisition for a low-cost storage oscilloscope. From a reference clock it makes a single sample strobe that serves both as the converter's sample clock and as the write enable of the capture FIFO, so every conversion lands in the FIFO on the strobe that produced it. The strobe spacing is one of eight power-of-two divisions of the reference clock, picked with a 3-bit select.

Once armed, the block sends exactly one record of 1024 strobe pulses. It then holds the strobe low while a slow host empties the FIFO, and starts the next record on its own when the FIFO reports empty. Every record is therefore contiguous in time, and gaps between records are accepted. An internal pulse counter cross-checks the FIFO's full flag. If the flag stays inactive after a complete record, the block latches a fault and holds the strobe off until reset.

The very first strobe of each record only primes the converter, so the first FIFO word of a record holds a stale conversion that the host discards.

Top module: `burst_capture_seq`

## Requirements
- R1: After a synchronous reset, `sampleStrobe`, `captureActive` and `captureFault` are all low. Reset is the only thing that clears `captureFault`.
- R2: When `arm` is sampled high while the block is idle and not faulted, `captureActive` is high in the next cycle. The first strobe pulse is high one cycle after that.
- R3: While capturing, the strobe pulses are one reference cycle wide and repeat every 2^`rateSel` cycles. `rateSel` = 0 gives a strobe that is high on every cycle, and `rateSel` = 7 gives one pulse every 128 cycles.
- R4: A record holds exactly 1024 strobe pulses. After the 1024th pulse the strobe stays low.
- R5: The full flag is active low. When `fullN` is sampled low during capture, the strobe is low from the next cycle on, and `captureActive` drops in that same cycle.
- R6: After a record ends through `fullN`, the block issues no strobe until `emptyN` (active low) is sampled low. It then starts a new record with the timing of R2.
- R7: `rateSel` is latched when a record starts, whether from `arm` or from the empty flag. Changing it during a record has no effect until the next record.
- R8: If 1024 pulses have been issued and `fullN` is still high on 4 consecutive clock edges, `captureFault` goes high and stays high, capture ends with the strobe low, and `arm` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Strobe divide select, divide by 2^rateSel |
| arm | input | 1 | Starts a capture from idle |
| fullN | input | 1 | FIFO full flag, active low |
| emptyN | input | 1 | FIFO empty flag, active low |
| sampleStrobe | output | 1 | Shared converter sample clock and FIFO write strobe |
| captureActive | output | 1 | High while a record is being captured |
| captureFault | output | 1 | Sticky fault: full flag missing after a complete record |

## Verification
An input sampled at a clock edge changes the state register at that edge. `captureActive` therefore follows one cycle after `arm`, `fullN` or `emptyN`. The strobe register is fed from that state, so the first pulse comes one cycle later again. A low `fullN` suppresses the strobe in the very next cycle, because it also feeds the strobe enable. The fault appears four edges after the 1024th pulse when the full flag stays high. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus to the cycle where the result is due, and it measures strobe spacing as the distance between sampled pulses. The bench also models the FIFO fill level, so the full and empty flags come back to the block with the same one-edge delay as a real FIFO.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRIME   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DRAIN   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBurst;   // latch rate, clear counters
    logic runEn;       // divider and strobe may run
    logic waitCount;   // count edges waiting for full flag
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic fire;        // a strobe pulse is issued at this edge
    logic burstDone;   // full record issued
    logic waitExpired; // full flag overdue
  } seqStat_t;

endpackage

// File: rtl/capseq_rate_div.sv
module capseq_rate_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              load,
  input  logic              run,
  output logic              tick
);
  localparam int DIV_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rateQ;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLimit;

  // thermometer limit: 2^rateQ - 1
  for (genvar g = 0; g < DIV_W; g++) begin : g_limit
    assign divLimit[g] = (RATE_W'(g) < rateQ);
  end

  always_ff @(posedge clk) begin
    if (rst)       rateQ <= '0;
    else if (load) rateQ <= rateSel;
  end

  always_ff @(posedge clk) begin
    if (rst || load || !run)     divCnt <= '0;
    else if (divCnt == divLimit) divCnt <= '0;
    else                         divCnt <= divCnt + 1'b1;
  end

  assign tick = run && (divCnt == '0);

endmodule

// File: rtl/capseq_datapath.sv
module capseq_datapath
  import capseq_pkg::*;
#(
  parameter int RATE_W    = 3,
  parameter int BURST_LEN = 1024,
  parameter int FULL_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              fullN,
  input  seqCtrl_t          ctrl,
  output seqStat_t          stat,
  output logic              sampleStrobe
);
  localparam int CNT_W  = $clog2(BURST_LEN + 1);
  localparam int WAIT_W = $clog2(FULL_WAIT + 1);

  logic              tick;
  logic              fire;
  logic              burstDone;
  logic              waitExpired;
  logic [CNT_W-1:0]  pulseCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              strobeQ;

  capseq_rate_div #(.RATE_W(RATE_W)) i_div (
    .clk     (clk),
    .rst     (rst),
    .rateSel (rateSel),
    .load    (ctrl.loadBurst),
    .run     (ctrl.runEn),
    .tick    (tick)
  );

  assign burstDone   = (pulseCnt == CNT_W'(BURST_LEN));
  assign waitExpired = (waitCnt == WAIT_W'(FULL_WAIT - 1));
  // enable is decided before the edge, so the registered strobe never runts
  assign fire        = tick && fullN && !burstDone;

  always_ff @(posedge clk) begin
    if (rst || ctrl.loadBurst) pulseCnt <= '0;
    else if (fire)             pulseCnt <= pulseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.waitCount) waitCnt <= '0;
    else if (!waitExpired)      waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) strobeQ <= 1'b0;
    else     strobeQ <= fire;
  end

  assign sampleStrobe     = strobeQ;
  assign stat.fire        = fire;
  assign stat.burstDone   = burstDone;
  assign stat.waitExpired = waitExpired;

endmodule

// File: rtl/capseq_control.sv
module capseq_control
  import capseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     arm,
  input  logic     fullN,
  input  logic     emptyN,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     captureActive,
  output logic     captureFault
);
  seqState_t state, stateNext;
  logic      faultQ, faultSet;

  always_comb begin
    stateNext      = state;
    faultSet       = 1'b0;
    ctrl.loadBurst = 1'b0;
    ctrl.runEn     = 1'b0;
    ctrl.waitCount = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (arm && !faultQ) begin
          ctrl.loadBurst = 1'b1;
          stateNext      = ST_PRIME;
        end
      end
      ST_PRIME: begin
        ctrl.runEn = 1'b1;
        if (!fullN)         stateNext = ST_DRAIN;
        else if (stat.fire) stateNext = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        ctrl.runEn     = 1'b1;
        ctrl.waitCount = stat.burstDone && fullN;
        if (!fullN) begin
          stateNext = ST_DRAIN;
        end else if (stat.burstDone && stat.waitExpired) begin
          faultSet  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (!emptyN) begin
          ctrl.loadBurst = 1'b1;
          stateNext      = ST_PRIME;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (rst)           faultQ <= 1'b0;
    else if (faultSet) faultQ <= 1'b1;
  end

  assign captureActive = (state == ST_PRIME) || (state == ST_CAPTURE);
  assign captureFault  = faultQ;

endmodule

// File: rtl/burst_capture_seq.sv
module burst_capture_seq
  import capseq_pkg::*;
#(
  parameter int RATE_W    = 3,
  parameter int BURST_LEN = 1024,
  parameter int FULL_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              arm,
  input  logic              fullN,
  input  logic              emptyN,
  output logic              sampleStrobe,
  output logic              captureActive,
  output logic              captureFault
);
  seqCtrl_t ctrl;
  seqStat_t stat;

  capseq_control i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .arm           (arm),
    .fullN         (fullN),
    .emptyN        (emptyN),
    .stat          (stat),
    .ctrl          (ctrl),
    .captureActive (captureActive),
    .captureFault  (captureFault)
  );

  capseq_datapath #(
    .RATE_W    (RATE_W),
    .BURST_LEN (BURST_LEN),
    .FULL_WAIT (FULL_WAIT)
  ) i_dp (
    .clk          (clk),
    .rst          (rst),
    .rateSel      (rateSel),
    .fullN        (fullN),
    .ctrl         (ctrl),
    .stat         (stat),
    .sampleStrobe (sampleStrobe)
  );

endmodule

// File: rtl/capseq_checker.sv
module capseq_checker (
  input logic clk,
  input logic rst,
  input logic fullN,
  input logic sampleStrobe,
  input logic captureActive,
  input logic captureFault
);

  // R5: a low full flag stops the strobe in the next cycle
  p_no_strobe_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    !fullN |=> !sampleStrobe);

  // R5: a low full flag ends the active phase
  p_active_ends_on_full_r5: assert property (@(posedge clk) disable iff (rst)
    (captureActive && !fullN) |=> !captureActive);

  // R2 / R6: strobe pulses only come out of an active capture
  p_strobe_from_capture_r2: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> $past(captureActive));

  // R8: the fault is sticky
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    captureFault |=> captureFault);

  // R8: no strobe and no capture while faulted
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    captureFault |-> (!sampleStrobe && !captureActive));

endmodule

bind burst_capture_seq capseq_checker i_capseq_checker (
  .clk           (clk),
  .rst           (rst),
  .fullN         (fullN),
  .sampleStrobe  (sampleStrobe),
  .captureActive (captureActive),
  .captureFault  (captureFault)
);

// File: tb/test_burst_capture_seq.sv
module test_burst_capture_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic       arm = 1'b0;
  logic       fullN;
  logic       emptyN;
  logic       sampleStrobe;
  logic       captureActive;
  logic       captureFault;

  // FIFO model
  int   fifoLevel;
  logic drainOn = 1'b0;
  logic forceFull = 1'b0;
  logic maskFull = 1'b0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  burst_capture_seq i_burst_capture_seq (
    .clk           (clk),
    .rst           (rst),
    .rateSel       (rateSel),
    .arm           (arm),
    .fullN         (fullN),
    .emptyN        (emptyN),
    .sampleStrobe  (sampleStrobe),
    .captureActive (captureActive),
    .captureFault  (captureFault)
  );

  always @(posedge clk) begin
    if (rst) fifoLevel <= 0;
    else fifoLevel <= fifoLevel + (sampleStrobe ? 1 : 0)
                      - ((drainOn && fifoLevel != 0) ? 1 : 0);
  end

  assign fullN  = forceFull ? 1'b0 : (maskFull ? 1'b1 : !(fifoLevel >= 1024));
  assign emptyN = !(fifoLevel == 0);

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; arm = 1'b0; drainOn = 1'b0; forceFull = 1'b0; maskFull = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // counts pulses in the next 'cycles' falling edges; gaps in cycles
  task automatic observe(input int cycles, input bit fromPulse,
                         output int pulses, output int minGap, output int maxGap);
    int last;
    last = fromPulse ? 0 : -1;
    pulses = 0; minGap = 1 << 30; maxGap = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (sampleStrobe) begin
        pulses++;
        if (last >= 0) begin
          if (i - last < minGap) minGap = i - last;
          if (i - last > maxGap) maxGap = i - last;
        end
        last = i;
      end
    end
  endtask

  // arm and check R2 timing; returns at the falling edge showing the first pulse
  task automatic armAndCheck(input logic [2:0] r, input string tag);
    @(negedge clk);
    rateSel = r; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk({"R2 active next cycle ", tag}, captureActive, 1);
    chk({"R2 no strobe yet ", tag}, sampleStrobe, 0);
    @(negedge clk);
    chk({"R2 first pulse ", tag}, sampleStrobe, 1);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset strobe", sampleStrobe, 0);
    chk("R1 reset active", captureActive, 0);
    chk("R1 reset fault", captureFault, 0);
  endtask

  task automatic testBurst(input logic [2:0] r);
    int p, mn, mx, n;
    n = 1 << r;
    armAndCheck(r, "burst");
    observe(1023 * n + 30, 1'b1, p, mn, mx);
    chk("R4 pulses per record", p + 1, 1024);
    chk("R3 min gap", mn, n);
    chk("R3 max gap", mx, n);
    chk("R5 inactive after full", captureActive, 0);
    observe(20, 1'b0, p, mn, mx);
    chk("R5 no pulse while full", p, 0);
  endtask

  // drain after a full record, restart with a new rate
  task automatic testDrainRestart(input logic [2:0] newRate);
    int p, mn, mx, quiet, guard;
    quiet = 0; guard = 0;
    @(negedge clk);
    drainOn = 1'b1;
    rateSel = newRate;
    while (emptyN && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (sampleStrobe) quiet++;
    end
    drainOn = 1'b0;
    chk("R6 no pulse during drain", quiet, 0);
    chk("R6 not active before empty seen", captureActive, 0);
    @(negedge clk);
    chk("R6 active after empty", captureActive, 1);
    chk("R6 no strobe yet", sampleStrobe, 0);
    @(negedge clk);
    chk("R6 first pulse after empty", sampleStrobe, 1);
    observe(20, 1'b1, p, mn, mx);
    chk("R7 new rate gap", mx, 1 << newRate);
  endtask

  task automatic testRateHold();
    int p, mn, mx;
    doReset();
    armAndCheck(3'd1, "rate hold");
    observe(10, 1'b1, p, mn, mx);
    @(negedge clk);
    rateSel = 3'd0;
    observe(40, 1'b0, p, mn, mx);
    chk("R7 min gap unchanged", mn, 2);
    chk("R7 max gap unchanged", mx, 2);
  endtask

  task automatic testSlowRate();
    int p, mn, mx;
    doReset();
    armAndCheck(3'd7, "rate 7");
    observe(128 * 4 + 10, 1'b1, p, mn, mx);
    chk("R3 rate 7 pulses", p, 4);
    chk("R3 rate 7 gap min", mn, 128);
    chk("R3 rate 7 gap max", mx, 128);
  endtask

  task automatic testEarlyFull();
    int p, mn, mx;
    doReset();
    armAndCheck(3'd0, "early full");
    observe(50, 1'b1, p, mn, mx);
    forceFull = 1'b1;
    @(negedge clk);
    chk("R5 strobe off after full", sampleStrobe, 0);
    chk("R5 active off after full", captureActive, 0);
    observe(20, 1'b0, p, mn, mx);
    chk("R5 no pulse while full held", p, 0);
    forceFull = 1'b0;
    observe(10, 1'b0, p, mn, mx);
    chk("R6 no restart while not empty", p, 0);
    chk("R6 idle while not empty", captureActive, 0);
  endtask

  task automatic testFault();
    int p, mn, mx;
    doReset();
    maskFull = 1'b1;
    armAndCheck(3'd0, "fault");
    observe(1023 + 12, 1'b1, p, mn, mx);
    chk("R8 record length without full", p + 1, 1024);
    chk("R8 fault set", captureFault, 1);
    chk("R8 strobe off", sampleStrobe, 0);
    chk("R8 inactive", captureActive, 0);
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk("R8 arm ignored active", captureActive, 0);
    observe(10, 1'b0, p, mn, mx);
    chk("R8 arm ignored pulses", p, 0);
    chk("R8 fault still set", captureFault, 1);
    doReset();
    chk("R1 reset clears fault", captureFault, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testBurst(3'd0);
    testDrainRestart(3'd1);
    doReset();
    testBurst(3'd2);
    testDrainRestart(3'd0);
    testRateHold();
    testSlowRate();
    testEarlyFull();
    testFault();
    summary();
    $finish;
  end

endmodule